// File: doc/BRIEF.md
# Shared Interrupt Sense and Route Unit

This unit conditions a parameterised group of external interrupt lines and hands each of them to exactly one processor core. Every line passes through a short synchroniser. Per line, software chooses the sensing: active-high or active-low level, rising or falling edge, or both edges. An edge is latched into a pending flag. A level is reported for as long as it is present. Software can also raise or drop any line's latched pending flag through an assert/clear word. That clear is also how an edge-latched event is acknowledged.

Each line has an enable (mask) bit, changed only through write-one-to-set and write-one-to-clear words, and a binary core number that routes it. The unit drives one interrupt output per core. An output is high while any line routed to that core is both pending and enabled. Configuration, mask strobes, software assert/clear and status reads all travel over a simple single-cycle word bus. Reads are combinational from the addressed word.

Top module: `sh_irq_router`

## Requirements
- R1: After reset every line is active-high (polarity bit 1), level sensed (trigger bit 0), with dual-edge off, disabled (mask bit 0), routed to core 0, and with its pending latch clear.
- R2: The word at region 0, index 0 reads NUM_SRC/8-1 in bits [23:16] and NUM_CORE-1 in bits [7:0], with all other bits zero. NUM_SRC must be a multiple of 8.
- R3: The word address is {region[2:0], index}. Per-line words use region 1 for polarity, 2 for trigger, 3 for dual-edge, 4 and 5 for the mask (both regions read the mask), and 6 for pending (read only). In these words, line n sits at index n/32, bit n%32. Bits for lines at or above NUM_SRC read zero and ignore writes.
- R4: A write to region 4 enables every line whose bit is 1, and a write to region 5 disables every line whose bit is 1. Zero bits leave the mask unchanged.
- R5: A level-sensed line is pending while its synchronised input equals its polarity bit (1 = high active, 0 = low active). The synchroniser has SYNC_STAGES flops.
- R6: An edge-sensed line (trigger bit 1) with dual-edge off latches pending on a rising input when polarity is 1, or on a falling input when polarity is 0. The opposite edge is ignored.
- R7: An edge-sensed line with dual-edge on latches pending on both transitions, whatever its polarity bit.
- R8: A write to region 0, index 1 with bit 31 = 1 sets the pending latch of the line numbered in the low bits. With bit 31 = 0, it clears that latch, which acknowledges an edge event. A line number at or above NUM_SRC is ignored. If a hardware edge arrives in the same cycle as a clear, the edge is kept.
- R9: A write to region 7, index n stores the core number held in the low bits of the data as line n's route, and the word reads it back. A core number at or above NUM_CORE is ignored.
- R10: irq_out[c] is the OR over all lines of pending AND enabled AND routed to core c. It is derived without further delay from registered state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | NUM_SRC | Asynchronous interrupt lines |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3+clog2(NUM_SRC) | Word address {region, index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| irq_out | output | NUM_CORE | One interrupt request per core |

## Verification
The bench builds the unit with 40 lines and 3 cores. With 40 lines, the per-line words span two indices, line 39 lands in bit 7 of the second word, and the unused upper bits of that word can be shown to read zero. The configuration field reads 4. Three cores give a two-bit route field, so core number 3 exists as an encoding but is not a valid core, which allows the ignored route write to be exercised.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  typedef enum logic [2:0] {
    RG_CTL   = 3'd0,
    RG_POL   = 3'd1,
    RG_TRIG  = 3'd2,
    RG_DUAL  = 3'd3,
    RG_MSET  = 3'd4,
    RG_MCLR  = 3'd5,
    RG_PEND  = 3'd6,
    RG_ROUTE = 3'd7
  } region_e;

  // level line is active when the input equals the polarity bit
  function automatic logic level_active(input logic cur, input logic pol);
    return cur ~^ pol;
  endfunction

  // edge qualifier from current and previous synchronised samples
  function automatic logic edge_fire(input logic cur, input logic prev,
                                     input logic pol, input logic dual);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return dual ? (rise | fall) : (pol ? rise : fall);
  endfunction

endpackage

// File: rtl/irqr_cfg_regs.sv
module irqr_cfg_regs
  import irqr_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int SRC_W    = 4,
  parameter int CORE_W   = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr,
  input  region_e                        region,
  input  logic [SRC_W-1:0]               idx,
  input  logic [31:0]                    wdata,
  output logic [NUM_SRC-1:0]             pol_q,
  output logic [NUM_SRC-1:0]             trig_q,
  output logic [NUM_SRC-1:0]             dual_q,
  output logic [NUM_SRC-1:0]             mask_q,
  output logic [NUM_SRC-1:0][CORE_W-1:0] route_q,
  output logic [NUM_SRC-1:0]             sw_set,
  output logic [NUM_SRC-1:0]             sw_clr
);

  logic sw_hit;
  logic route_ok;

  assign sw_hit   = wr && (region == RG_CTL) && (idx == SRC_W'(1));
  assign route_ok = int'(wdata[CORE_W-1:0]) < NUM_CORE;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      sw_set[s] = sw_hit &&  wdata[31] && (wdata[SRC_W-1:0] == SRC_W'(s));
      sw_clr[s] = sw_hit && !wdata[31] && (wdata[SRC_W-1:0] == SRC_W'(s));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= '1;
      trig_q  <= '0;
      dual_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (idx == SRC_W'(s / 32)) begin
          case (region)
            RG_POL:  pol_q[s]  <= wdata[s % 32];
            RG_TRIG: trig_q[s] <= wdata[s % 32];
            RG_DUAL: dual_q[s] <= wdata[s % 32];
            RG_MSET: if (wdata[s % 32]) mask_q[s] <= 1'b1;
            RG_MCLR: if (wdata[s % 32]) mask_q[s] <= 1'b0;
            default: ;
          endcase
        end
        if (region == RG_ROUTE && idx == SRC_W'(s) && route_ok)
          route_q[s] <= wdata[CORE_W-1:0];
      end
    end
  end

endmodule

// File: rtl/irqr_sense.sv
module irqr_sense
  import irqr_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] pol_q,
  input  logic [NUM_SRC-1:0] trig_q,
  input  logic [NUM_SRC-1:0] dual_q,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_clr,
  output logic [NUM_SRC-1:0] edge_evt,
  output logic [NUM_SRC-1:0] pend_latch,
  output logic [NUM_SRC-1:0] pending
);

  logic [SYNC_STAGES-1:0][NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] cur;
  logic [NUM_SRC-1:0] lvl_act;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      prev_q     <= '0;
      pend_latch <= '0;
    end else begin
      sync_q[0] <= src_in;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q     <= cur;
      pend_latch <= (pend_latch & ~sw_clr) | sw_set | edge_evt;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign edge_evt[s] = trig_q[s] & edge_fire(cur[s], prev_q[s], pol_q[s], dual_q[s]);
    assign lvl_act[s]  = ~trig_q[s] & level_active(cur[s], pol_q[s]);
  end

  assign pending = lvl_act | pend_latch;

endmodule

// File: rtl/irqr_merge.sv
module irqr_merge #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int CORE_W   = 1
) (
  input  logic [NUM_SRC-1:0]             pending,
  input  logic [NUM_SRC-1:0]             mask_q,
  input  logic [NUM_SRC-1:0][CORE_W-1:0] route_q,
  output logic [NUM_CORE-1:0]            irq_out
);

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    logic [NUM_SRC-1:0] sel;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) sel[s] = (route_q[s] == CORE_W'(c));
    end
    assign irq_out[c] = |(pending & mask_q & sel);
  end

endmodule

// File: rtl/sh_irq_router.sv
module sh_irq_router
  import irqr_pkg::*;
#(
  parameter int NUM_SRC     = 16,
  parameter int NUM_CORE    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SRC-1:0]           src_in,
  input  logic                         bus_wr,
  input  logic [3+$clog2(NUM_SRC)-1:0] bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic [NUM_CORE-1:0]          irq_out
);

  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int ADDR_W = 3 + SRC_W;
  localparam int CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam int NWORD  = (NUM_SRC + 31) / 32;
  localparam int PADW   = NWORD * 32;
  localparam logic [31:0] CFG_WORD = (32'(NUM_SRC / 8 - 1) << 16) | 32'(NUM_CORE - 1);

  region_e              region;
  logic [SRC_W-1:0]     idx;
  logic [NUM_SRC-1:0]   pol_q, trig_q, dual_q, mask_q;
  logic [NUM_SRC-1:0][CORE_W-1:0] route_q;
  logic [NUM_SRC-1:0]   sw_set, sw_clr, edge_evt, pend_latch, pending;
  logic [PADW-1:0]      pol_pad, trig_pad, dual_pad, mask_pad, pend_pad;

  assign region = region_e'(bus_addr[ADDR_W-1 -: 3]);
  assign idx    = bus_addr[SRC_W-1:0];

  irqr_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .SRC_W(SRC_W), .CORE_W(CORE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .region(region), .idx(idx), .wdata(bus_wdata),
    .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q), .mask_q(mask_q), .route_q(route_q),
    .sw_set(sw_set), .sw_clr(sw_clr)
  );

  irqr_sense #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst(rst), .src_in(src_in), .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q),
    .sw_set(sw_set), .sw_clr(sw_clr), .edge_evt(edge_evt), .pend_latch(pend_latch),
    .pending(pending)
  );

  irqr_merge #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .CORE_W(CORE_W)) u_merge (
    .pending(pending), .mask_q(mask_q), .route_q(route_q), .irq_out(irq_out)
  );

  assign pol_pad  = PADW'(pol_q);
  assign trig_pad = PADW'(trig_q);
  assign dual_pad = PADW'(dual_q);
  assign mask_pad = PADW'(mask_q);
  assign pend_pad = PADW'(pending);

  function automatic logic [31:0] pick_word(input logic [PADW-1:0] v, input logic [SRC_W-1:0] i);
    logic [31:0] r;
    r = '0;
    for (int w = 0; w < NWORD; w++) if (i == SRC_W'(w)) r = v[w*32 +: 32];
    return r;
  endfunction

  always_comb begin
    bus_rdata = '0;
    case (region)
      RG_CTL:           if (idx == '0) bus_rdata = CFG_WORD;
      RG_POL:           bus_rdata = pick_word(pol_pad, idx);
      RG_TRIG:          bus_rdata = pick_word(trig_pad, idx);
      RG_DUAL:          bus_rdata = pick_word(dual_pad, idx);
      RG_MSET, RG_MCLR: bus_rdata = pick_word(mask_pad, idx);
      RG_PEND:          bus_rdata = pick_word(pend_pad, idx);
      RG_ROUTE: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (idx == SRC_W'(s)) bus_rdata = 32'(route_q[s]);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irqr_checker.sv
module irqr_checker
  import irqr_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_wr,
  input logic [3+$clog2(NUM_SRC)-1:0] bus_addr,
  input logic [31:0]                  bus_wdata,
  input logic [NUM_SRC-1:0]           pol_q,
  input logic [NUM_SRC-1:0]           trig_q,
  input logic [NUM_SRC-1:0]           dual_q,
  input logic [NUM_SRC-1:0]           mask_q,
  input logic [NUM_SRC-1:0]           sw_set,
  input logic [NUM_SRC-1:0]           sw_clr,
  input logic [NUM_SRC-1:0]           edge_evt,
  input logic [NUM_SRC-1:0]           pend_latch,
  input logic [NUM_SRC-1:0]           pending,
  input logic [NUM_CORE-1:0]          irq_out
);

  localparam int SRC_W = $clog2(NUM_SRC);
  localparam int W0    = (NUM_SRC < 32) ? NUM_SRC : 32;

  logic [2:0]       rg;
  logic [SRC_W-1:0] ix;
  logic             mset_w0, mclr_w0;

  assign rg      = bus_addr[SRC_W+2 -: 3];
  assign ix      = bus_addr[SRC_W-1:0];
  assign mset_w0 = bus_wr && rg == RG_MSET && ix == '0;
  assign mclr_w0 = bus_wr && rg == RG_MCLR && ix == '0;

  assert_reset_state_R1: assert property (@(posedge clk)
    $fell(rst) |-> (mask_q == '0 && trig_q == '0 && dual_q == '0 && (&pol_q) && pend_latch == '0));

  assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
    mset_w0 |=> ((mask_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == $past(bus_wdata[W0-1:0])));

  assert_mask_clear_R4: assert property (@(posedge clk) disable iff (rst)
    mclr_w0 |=> ((mask_q[W0-1:0] & $past(bus_wdata[W0-1:0])) == '0));

  assert_latch_source_R6: assert property (@(posedge clk) disable iff (rst)
    ((pend_latch & ~$past(pend_latch) & ~$past(edge_evt | sw_set)) == '0));

  assert_latch_ack_R8: assert property (@(posedge clk) disable iff (rst)
    ((~pend_latch & $past(pend_latch) & ~$past(sw_clr)) == '0));

  assert_quiet_output_R10: assert property (@(posedge clk) disable iff (rst)
    ((pending & mask_q) == '0) |-> (irq_out == '0));

endmodule

bind sh_irq_router irqr_checker #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) u_irqr_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pol_q(pol_q), .trig_q(trig_q), .dual_q(dual_q), .mask_q(mask_q), .sw_set(sw_set),
  .sw_clr(sw_clr), .edge_evt(edge_evt), .pend_latch(pend_latch), .pending(pending),
  .irq_out(irq_out)
);

// File: tb/test_sh_irq_router.sv
module test_sh_irq_router;

  localparam int NS = 40;
  localparam int NC = 3;
  localparam int AW = 3 + $clog2(NS);

  localparam int G_CTL = 0, G_POL = 1, G_TRIG = 2, G_DUAL = 3;
  localparam int G_MSET = 4, G_MCLR = 5, G_PEND = 6, G_ROUTE = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_in = '0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sh_irq_router #(.NUM_SRC(NS), .NUM_CORE(NC)) i_sh_irq_router (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int rg, input int ix, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = AW'((rg << (AW - 3)) | ix);
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int rg, input int ix, input logic [31:0] exp);
    bus_addr = AW'((rg << (AW - 3)) | ix);
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R2 config", G_CTL, 0, 32'h0004_0002);
    rd_chk("R1 pol w0", G_POL, 0, 32'hFFFF_FFFF);
    rd_chk("R3 pol w1 upper zero", G_POL, 1, 32'h0000_00FF);
    rd_chk("R1 trig w0", G_TRIG, 0, 32'h0);
    rd_chk("R1 dual w1", G_DUAL, 1, 32'h0);
    rd_chk("R1 mask w0", G_MSET, 0, 32'h0);
    rd_chk("R1 mask w1", G_MCLR, 1, 32'h0);
    rd_chk("R1 pend w0", G_PEND, 0, 32'h0);
    rd_chk("R1 route 39", G_ROUTE, 39, 32'h0);
    check("R1 irq_out", 32'(irq_out), 32'h0);
  endtask

  task automatic t_level();
    src_in[3] = 1'b1;
    wr(G_MSET, 0, 32'h8);
    tick(3);
    check("R5 R10 level high irq", 32'(irq_out), 32'h1);
    rd_chk("R5 pend bit3", G_PEND, 0, 32'h8);
    wr(G_MCLR, 0, 32'h8);
    check("R4 masked irq", 32'(irq_out), 32'h0);
    rd_chk("R4 pend kept when masked", G_PEND, 0, 32'h8);
    wr(G_MSET, 0, 32'h8);
    wr(G_MSET, 0, 32'h20);
    rd_chk("R4 zero bits keep mask", G_MSET, 0, 32'h28);
  endtask

  task automatic t_pol();
    wr(G_POL, 0, 32'hFFFF_FFDF);
    rd_chk("R5 low-active idle pending", G_PEND, 0, 32'h28);
    check("R10 irq core0", 32'(irq_out), 32'h1);
    src_in[5] = 1'b1;
    tick(3);
    rd_chk("R5 low-active released", G_PEND, 0, 32'h08);
    wr(G_POL, 0, 32'hFFFF_FFFF);
    src_in[5] = 1'b0;
    tick(3);
  endtask

  task automatic t_route();
    wr(G_ROUTE, 3, 32'd1);
    check("R9 R10 routed core1", 32'(irq_out), 32'h2);
    wr(G_ROUTE, 3, 32'd3);
    check("R9 bad core ignored", 32'(irq_out), 32'h2);
    rd_chk("R9 route readback", G_ROUTE, 3, 32'd1);
    src_in[3] = 1'b0;
    tick(3);
    check("R10 idle after drop", 32'(irq_out), 32'h0);
    wr(G_MCLR, 0, 32'h28);
  endtask

  task automatic t_edge();
    wr(G_TRIG, 1, 32'h10);
    wr(G_ROUTE, 36, 32'd2);
    wr(G_MSET, 1, 32'h10);
    src_in[36] = 1'b1;
    tick(4);
    rd_chk("R6 rising latched", G_PEND, 1, 32'h10);
    check("R10 core2 irq", 32'(irq_out), 32'h4);
    wr(G_CTL, 1, 32'd36);
    rd_chk("R8 clear acks edge", G_PEND, 1, 32'h0);
    check("R8 irq dropped", 32'(irq_out), 32'h0);
    src_in[36] = 1'b0;
    tick(4);
    rd_chk("R6 falling ignored", G_PEND, 1, 32'h0);
  endtask

  task automatic t_dual();
    wr(G_DUAL, 1, 32'h10);
    wr(G_POL, 1, 32'hEF);
    src_in[36] = 1'b1;
    tick(4);
    rd_chk("R7 rise latched", G_PEND, 1, 32'h10);
    wr(G_CTL, 1, 32'd36);
    src_in[36] = 1'b0;
    tick(4);
    rd_chk("R7 fall latched", G_PEND, 1, 32'h10);
    wr(G_CTL, 1, 32'd36);
    rd_chk("R8 cleared", G_PEND, 1, 32'h0);
    wr(G_DUAL, 1, 32'h0);
    wr(G_POL, 1, 32'hFF);
  endtask

  task automatic t_negedge();
    wr(G_TRIG, 1, 32'h30);
    wr(G_POL, 1, 32'hDF);
    src_in[37] = 1'b1;
    tick(4);
    rd_chk("R6 rise ignored low-active", G_PEND, 1, 32'h0);
    src_in[37] = 1'b0;
    tick(4);
    rd_chk("R6 fall latched low-active", G_PEND, 1, 32'h20);
    wr(G_CTL, 1, 32'd37);
    rd_chk("R8 clear 37", G_PEND, 1, 32'h0);
  endtask

  task automatic t_sw();
    wr(G_CTL, 1, 32'h8000_000A);
    rd_chk("R8 sw set", G_PEND, 0, 32'h400);
    wr(G_MSET, 0, 32'h400);
    check("R8 R10 sw irq core0", 32'(irq_out), 32'h1);
    wr(G_CTL, 1, 32'h0000_000A);
    rd_chk("R8 sw clear", G_PEND, 0, 32'h0);
    check("R8 irq idle", 32'(irq_out), 32'h0);
    wr(G_CTL, 1, 32'h8000_002D);
    rd_chk("R8 out of range w0", G_PEND, 0, 32'h0);
    rd_chk("R8 out of range w1", G_PEND, 1, 32'h0);
  endtask

  task automatic t_layout();
    wr(G_MSET, 1, 32'h80);
    rd_chk("R3 line39 word1 bit7", G_MSET, 1, 32'h90);
    rd_chk("R3 mask via region5", G_MCLR, 1, 32'h90);
    wr(G_MSET, 1, 32'hFFFF_FFFF);
    rd_chk("R3 unused bits zero", G_MSET, 1, 32'hFF);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_level();
    t_pol();
    t_route();
    t_edge();
    t_dual();
    t_negedge();
    t_sw();
    t_layout();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule